// File: doc/BRIEF.md
# Control and Status Register Bank with Pulse Fields

This block is a small memory-mapped register bank. It sits behind a simple register-bus slave port that has a single-cycle write channel with byte enables and a read channel with one cycle of latency. It holds a read-write control register, a write-only command register, a read-only status register fed from input pins, and a read-only revision register that returns a value fixed when the design is built.

Every field drives its own output port, and each writable register has its own write strobe. Some fields clear themselves: writing a one to such a field gives a pulse of one clock cycle on its port. Software uses these fields to trigger actions in the user logic. It reads the revision word to confirm that its register definitions match the hardware.

Word addresses are 0 for control, 1 for command, 2 for status and 3 for revision. Every other address is unmapped. All field outputs, strobes and read data come straight from flip-flops.

Top module: `regbank_top`

## Requirements
- R1: The control register (word address 0) holds `ctrl_run` at bit 0, `ctrl_mode` at bits 7:4, `ctrl_kick` at bit 8 and `ctrl_flush` at bit 24. A write updates only the bits whose byte lane has `wr_be` set (lane n covers bits 8n+7:8n). The outputs show the new value in the cycle after the write is sampled.
- R2: `ctrl_kick`, `ctrl_flush` and `cmd_trig` clear themselves. After a write of one they are high for exactly one cycle and then return to zero, even if the address stays on the bus. Writes on consecutive cycles keep them high for every cycle that follows a write.
- R3: A clock edge with `rst` high sets `ctrl_mode` to `MODE_RST` and drives every other field, both strobes, `rd_valid` and `rd_data` to zero.
- R4: `ctrl_stb` and `cmd_stb` are high for one cycle after each write to their register, in the same cycle in which the new field values appear. This holds for any data and any byte enables, including a write of unchanged data.
- R5: The write-only command register (word address 1) holds `cmd_trig` at bit 0 and `cmd_level` at bits 15:8. A read of it returns zero.
- R6: A read of the control register returns the fields at the bit positions given in R1, with the self-clearing bits in their current state. All other bits read as zero.
- R7: A read of the status register (word address 2) returns `stat_busy` at bit 0 and `stat_count` at bits 23:16, taken from the inputs when the read is sampled. A write to it changes nothing.
- R8: A read of word address 3 returns the parameter `REVISION`. A write to it changes nothing.
- R9: A write to an address of 4 or above changes no field and raises no strobe. A read of such an address returns zero.
- R10: `rd_valid` is high exactly in the cycle after each cycle in which `rd_en` is sampled high, and `rd_data` carries the read word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| ctrl_run | output | 1 | Control: run level |
| ctrl_mode | output | 4 | Control: mode |
| ctrl_kick | output | 1 | Control: self-clearing kick pulse |
| ctrl_flush | output | 1 | Control: self-clearing flush pulse |
| ctrl_stb | output | 1 | Control register write strobe |
| cmd_trig | output | 1 | Command: self-clearing trigger pulse |
| cmd_level | output | 8 | Command: level value |
| cmd_stb | output | 1 | Command register write strobe |
| stat_busy | input | 1 | Status: busy flag |
| stat_count | input | 8 | Status: count value |

## Verification
The bench builds the block with `ADDR_W` = 4, `MODE_RST` = 5 and `REVISION` = 32'h0003_0102. The non-zero mode reset value lets the bench tell a reset from a clear. The distinctive revision word makes a mis-routed read visible. With four address bits, twelve addresses are unmapped, so the bench can probe writes and reads to unmapped words above the decoded range. It also drives byte enables lane by lane, so that a lane that spills into its neighbour shows up on a field port.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  // word addresses
  localparam int IDX_CTRL = 0;
  localparam int IDX_CMD  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_REV  = 3;

  // control register layout
  localparam int RUN_LSB   = 0;
  localparam int MODE_LSB  = 4;
  localparam int MODE_W    = 4;
  localparam int KICK_LSB  = 8;
  localparam int FLUSH_LSB = 24;

  // command register layout
  localparam int TRIG_LSB  = 0;
  localparam int LEVEL_LSB = 8;
  localparam int LEVEL_W   = 8;

  // status register layout
  localparam int BUSY_LSB  = 0;
  localparam int COUNT_LSB = 16;
  localparam int COUNT_W   = 8;
endpackage

// File: rtl/regbank_field.sv
`timescale 1ns/1ps
module regbank_field
  import regbank_pkg::*;
#(
  parameter int           LSB      = 0,
  parameter int           W        = 1,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter bit           SELF_CLR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   wbe,
  output logic [W-1:0]      q
);
  logic [DATA_W-1:0] lane_mask;
  logic [W-1:0]      wmask;
  logic [W-1:0]      idle_val;
  logic [W-1:0]      nxt;

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    assign lane_mask[8*l +: 8] = {8{wbe[l]}};
  end

  assign wmask = lane_mask[LSB +: W];

  if (SELF_CLR) begin : g_pulse
    assign idle_val = '0;
  end else begin : g_hold
    assign idle_val = q;
  end

  always_comb begin
    if (wr) nxt = (wmask & wdata[LSB +: W]) | (~wmask & idle_val);
    else    nxt = idle_val;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt;
  end
endmodule

// File: rtl/regbank_rdmux.sv
`timescale 1ns/1ps
module regbank_rdmux
  import regbank_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [DATA_W-1:0] REVISION = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               run,
  input  logic [MODE_W-1:0]  mode,
  input  logic               kick,
  input  logic               flush,
  input  logic               busy,
  input  logic [COUNT_W-1:0] count,
  output logic [DATA_W-1:0]  word
);
  always_comb begin
    word = '0;
    if (addr == ADDR_W'(IDX_CTRL)) begin
      word[RUN_LSB]               = run;
      word[MODE_LSB +: MODE_W]    = mode;
      word[KICK_LSB]              = kick;
      word[FLUSH_LSB]             = flush;
    end else if (addr == ADDR_W'(IDX_STAT)) begin
      word[BUSY_LSB]              = busy;
      word[COUNT_LSB +: COUNT_W]  = count;
    end else if (addr == ADDR_W'(IDX_REV)) begin
      word = REVISION;
    end
    // the command register is write-only and falls through to zero
  end
endmodule

// File: rtl/regbank_top.sv
`timescale 1ns/1ps
module regbank_top
  import regbank_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [3:0]        MODE_RST = 4'h5,
  parameter logic [31:0]       REVISION = 32'h0003_0102
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              ctrl_run,
  output logic [3:0]        ctrl_mode,
  output logic              ctrl_kick,
  output logic              ctrl_flush,
  output logic              ctrl_stb,
  output logic              cmd_trig,
  output logic [7:0]        cmd_level,
  output logic              cmd_stb,
  input  logic              stat_busy,
  input  logic [7:0]        stat_count
);
  logic              hit_ctrl;
  logic              hit_cmd;
  logic [DATA_W-1:0] rd_word;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(IDX_CTRL));
  assign hit_cmd  = wr_en && (wr_addr == ADDR_W'(IDX_CMD));

  // control register fields
  regbank_field #(.LSB(RUN_LSB), .W(1), .RST_VAL(1'b0), .SELF_CLR(1'b0)) u_run (
    .clk(clk), .rst(rst), .wr(hit_ctrl), .wdata(wr_data), .wbe(wr_be), .q(ctrl_run));
  regbank_field #(.LSB(MODE_LSB), .W(MODE_W), .RST_VAL(MODE_RST), .SELF_CLR(1'b0)) u_mode (
    .clk(clk), .rst(rst), .wr(hit_ctrl), .wdata(wr_data), .wbe(wr_be), .q(ctrl_mode));
  regbank_field #(.LSB(KICK_LSB), .W(1), .RST_VAL(1'b0), .SELF_CLR(1'b1)) u_kick (
    .clk(clk), .rst(rst), .wr(hit_ctrl), .wdata(wr_data), .wbe(wr_be), .q(ctrl_kick));
  regbank_field #(.LSB(FLUSH_LSB), .W(1), .RST_VAL(1'b0), .SELF_CLR(1'b1)) u_flush (
    .clk(clk), .rst(rst), .wr(hit_ctrl), .wdata(wr_data), .wbe(wr_be), .q(ctrl_flush));

  // command register fields
  regbank_field #(.LSB(TRIG_LSB), .W(1), .RST_VAL(1'b0), .SELF_CLR(1'b1)) u_trig (
    .clk(clk), .rst(rst), .wr(hit_cmd), .wdata(wr_data), .wbe(wr_be), .q(cmd_trig));
  regbank_field #(.LSB(LEVEL_LSB), .W(LEVEL_W), .RST_VAL(8'h00), .SELF_CLR(1'b0)) u_level (
    .clk(clk), .rst(rst), .wr(hit_cmd), .wdata(wr_data), .wbe(wr_be), .q(cmd_level));

  // write strobes, aligned with the field update
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_stb <= 1'b0;
      cmd_stb  <= 1'b0;
    end else begin
      ctrl_stb <= hit_ctrl;
      cmd_stb  <= hit_cmd;
    end
  end

  regbank_rdmux #(.ADDR_W(ADDR_W), .REVISION(REVISION)) u_rdmux (
    .addr(rd_addr), .run(ctrl_run), .mode(ctrl_mode), .kick(ctrl_kick),
    .flush(ctrl_flush), .busy(stat_busy), .count(stat_count), .word(rd_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/regbank_chk.sv
`timescale 1ns/1ps
module regbank_chk #(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] REVISION = 32'h0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [3:0]        wr_be,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic              ctrl_run,
  input logic              ctrl_kick,
  input logic              ctrl_stb,
  input logic              cmd_trig,
  input logic              cmd_stb
);
  logic wr_ctrl, wr_cmd;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(0));
  assign wr_cmd  = wr_en && (wr_addr == ADDR_W'(1));

  AST_KICK_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_kick && !(wr_ctrl && wr_be[1] && wr_data[8])) |=> !ctrl_kick); // R2
  AST_TRIG_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmd_trig && !(wr_cmd && wr_be[0] && wr_data[0])) |=> !cmd_trig); // R2
  AST_CTRL_STB_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ctrl_stb); // R4
  AST_CTRL_STB_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> !ctrl_stb); // R4
  AST_CMD_STB_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_cmd |=> !cmd_stb); // R9
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ctrl_run)); // R1
  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R10
  AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R10
  AST_REV_CONSTANT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(3)) |=> (rd_data == REVISION)); // R8
endmodule

bind regbank_top regbank_chk #(.ADDR_W(ADDR_W), .REVISION(REVISION)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .rd_valid(rd_valid), .ctrl_run(ctrl_run), .ctrl_kick(ctrl_kick),
  .ctrl_stb(ctrl_stb), .cmd_trig(cmd_trig), .cmd_stb(cmd_stb));

// File: tb/tb_regbank_top.sv
`timescale 1ns/1ps
module tb_regbank_top;
  localparam int          ADDR_W   = 4;
  localparam logic [3:0]  MODE_RST = 4'h5;
  localparam logic [31:0] REV      = 32'h0003_0102;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [3:0]        wr_be = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  logic              rd_valid;
  logic              ctrl_run, ctrl_kick, ctrl_flush, ctrl_stb;
  logic [3:0]        ctrl_mode;
  logic              cmd_trig, cmd_stb;
  logic [7:0]        cmd_level;
  logic              stat_busy = 1'b0;
  logic [7:0]        stat_count = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regbank_top #(.ADDR_W(ADDR_W), .MODE_RST(MODE_RST), .REVISION(REV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .ctrl_run(ctrl_run), .ctrl_mode(ctrl_mode),
    .ctrl_kick(ctrl_kick), .ctrl_flush(ctrl_flush), .ctrl_stb(ctrl_stb),
    .cmd_trig(cmd_trig), .cmd_level(cmd_level), .cmd_stb(cmd_stb),
    .stat_busy(stat_busy), .stat_count(stat_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one write; returns at the falling edge right after it is taken.
  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  function automatic logic [31:0] ctrl_word();
    return {7'd0, ctrl_flush, 15'd0, ctrl_kick, ctrl_mode, 3'd0, ctrl_run};
  endfunction

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk("R3 mode reset", {28'd0, ctrl_mode}, {28'd0, MODE_RST});
    chk("R3 fields reset", {ctrl_run, ctrl_kick, ctrl_flush, cmd_trig, ctrl_stb, cmd_stb}, 32'd0);
    chk("R3 level reset", {24'd0, cmd_level}, 32'd0);
    chk("R3 read port reset", {rd_data[31:1], rd_valid}, 32'd0);
    bus_rd(4'd0, d, v);
    chk("R6 ctrl read after reset", d, 32'h0000_0050);
    chk("R10 rd_valid", {31'd0, v}, 32'd1);
    @(negedge clk);
    chk("R10 rd_valid drops", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_ctrl_write();
    logic [31:0] d; logic v;
    bus_wr(4'd0, 32'h0100_01A1, 4'b1111);
    chk("R1 full write fields", ctrl_word(), 32'h0100_01A1);
    chk("R4 ctrl strobe", {31'd0, ctrl_stb}, 32'd1);
    @(negedge clk);
    chk("R2 pulses cleared", {30'd0, ctrl_kick, ctrl_flush}, 32'd0);
    chk("R4 strobe one cycle", {31'd0, ctrl_stb}, 32'd0);
    bus_rd(4'd0, d, v);
    chk("R6 ctrl readback", d, 32'h0000_00A1);
    // lane 1 only: just kick may change
    bus_wr(4'd0, 32'hFFFF_FFFF, 4'b0010);
    chk("R1 lane1 only", ctrl_word(), 32'h0000_01A1);
    // lane 0 only
    bus_wr(4'd0, 32'hFFFF_FF30, 4'b0001);
    chk("R1 lane0 only", ctrl_word(), 32'h0000_0030);
    // lane 3 only: flush
    bus_wr(4'd0, 32'hFFFF_FFFF, 4'b1000);
    chk("R1 lane3 only", ctrl_word(), 32'h0100_0030);
  endtask

  task automatic t_pulses();
    // address and data stay on the bus, wr_en drops
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h0000_0001; wr_be = 4'b0001;
    @(negedge clk);
    chk("R2 trig high", {31'd0, cmd_trig}, 32'd1);
    chk("R5 cmd strobe", {31'd0, cmd_stb}, 32'd1);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R2 trig cleared with address held", {31'd0, cmd_trig}, 32'd0);
    // back-to-back writes of kick: two cycles high
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h0000_0100; wr_be = 4'b0010;
    @(negedge clk);
    chk("R2 back-to-back first", {31'd0, ctrl_kick}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 back-to-back second", {31'd0, ctrl_kick}, 32'd1);
    chk("R4 strobe each write", {31'd0, ctrl_stb}, 32'd1);
    @(negedge clk);
    chk("R2 back-to-back ends", {31'd0, ctrl_kick}, 32'd0);
  endtask

  task automatic t_strobe_no_change();
    bus_wr(4'd0, 32'h0, 4'b0000);
    chk("R4 strobe with no lanes", {31'd0, ctrl_stb}, 32'd1);
    chk("R4 fields unchanged", ctrl_word(), 32'h0000_0030);
  endtask

  task automatic t_cmd();
    logic [31:0] d; logic v;
    bus_wr(4'd1, 32'h0000_C300, 4'b0010);
    chk("R5 level written", {24'd0, cmd_level}, 32'h0000_00C3);
    chk("R5 trig untouched", {31'd0, cmd_trig}, 32'd0);
    bus_rd(4'd1, d, v);
    chk("R5 write-only reads zero", d, 32'd0);
  endtask

  task automatic t_status_rev();
    logic [31:0] d; logic v;
    stat_busy = 1'b1; stat_count = 8'h9E;
    bus_rd(4'd2, d, v);
    chk("R7 status read", d, 32'h009E_0001);
    bus_wr(4'd2, 32'hFFFF_FFFF, 4'b1111);
    chk("R7 status write no strobe", {30'd0, ctrl_stb, cmd_stb}, 32'd0);
    stat_busy = 1'b0; stat_count = 8'h11;
    bus_rd(4'd2, d, v);
    chk("R7 status follows inputs", d, 32'h0011_0000);
    bus_wr(4'd3, 32'h0, 4'b1111);
    bus_rd(4'd3, d, v);
    chk("R8 revision", d, REV);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic v;
    bus_wr(4'd4, 32'hFFFF_FFFF, 4'b1111);
    chk("R9 no strobe", {30'd0, ctrl_stb, cmd_stb}, 32'd0);
    chk("R9 no field change", ctrl_word(), 32'h0000_0030);
    chk("R9 no pulse", {31'd0, cmd_trig}, 32'd0);
    bus_wr(4'd15, 32'hFFFF_FFFF, 4'b1111);
    chk("R9 level unchanged", {24'd0, cmd_level}, 32'h0000_00C3);
    bus_rd(4'd9, d, v);
    chk("R9 unmapped read zero", d, 32'd0);
    chk("R10 valid on unmapped read", {31'd0, v}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_write();
    t_pulses();
    t_strobe_no_change();
    t_cmd();
    t_status_rev();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule